// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

A single timer channel built around an internal up-counter and two compare slots, called A and B. Each slot holds a staging value and a live value. Software loads the staging value through a small write port. The channel copies the staging value into the live value only at moments that the active sub-mode defines, so a waveform never sees a half-updated pair of compare values. The live values can also be loaded directly when the channel is first set up.

Three sub-modes share the counter. The modulus time base counts up and reloads itself on an A match. The self-timed PWM sets its own period from B and its edge position from A. The shifted PWM runs the counter freely: A places the leading edge, B places the trailing edge, and the staged A value acts as a separate trigger point that raises the flag, for example to start a conversion. A fourth code parks the channel. A polarity input selects which output level counts as active. A sticky flag reports events until software clears it.

Top module: `pwm_cmp_channel`

## Requirements
- R1: While reset is held, `count` is 0, `flag` is 0 and `pwm_out` is 0. The mode register resets to the parked code (3).
- R2: A write with `wr_en` high stores `wr_data` at the next clock edge. The target follows `wr_sel`: 0 is the A staging register, 1 is the B staging register, 2 is the live A register and 3 is the live B register. A direct live write takes priority over a transfer in the same cycle.
- R3: In modulus mode (`mode_sel`=0), when the counter equals live A, the counter loads 1 on the next edge and the flag is set. Otherwise it counts up by one and wraps from its maximum to 0. `pwm_out` holds the inactive level (the inverse of `polarity`).
- R4: In modulus mode, staged A is copied into live A only on an edge where the counter equals 1.
- R5: If the counter is above live A when modulus mode starts, it counts up to its all-ones value, wraps to 0 and only then reaches the match.
- R6: In self-timed PWM mode (`mode_sel`=1), an A match drives `pwm_out` to `polarity`. A B match drives it to the inverse of `polarity` and clears the counter. The period is B+1 counts, of which A+1 counts are at the inverse level. The B match always sets the flag.
- R7: In self-timed PWM mode, both staged values are copied into the live registers on the first edge after a B match, which is the edge where the counter is 0.
- R8: In self-timed PWM mode, the A match also sets the flag only when `flag_on_lead` is 1.
- R9: In shifted PWM mode (`mode_sel`=2), the counter runs freely and wraps. An A match drives `pwm_out` to `polarity` and copies staged B into live B. A B match drives `pwm_out` to the inverse level and wins if both match.
- R10: In shifted PWM mode, a counter value equal to staged A sets the flag.
- R11: The flag stays set until a cycle with `flag_clr` high. A set event in the same cycle as a clear leaves the flag set.
- R12: On the edge where `mode_sel` differs from the stored mode, the counter holds, `pwm_out` goes to the inverse of `polarity`, no flag is raised and no transfer happens. The buffered registers keep their values.
- R13: In the parked mode (`mode_sel`=3), the counter holds, `pwm_out` follows the inverse of `polarity` and the flag is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the compare registers |
| wr_sel | input | 2 | Register select: 0 A stage, 1 B stage, 2 A live, 3 B live |
| wr_data | input | CNT_W | Write value |
| mode_sel | input | 2 | 0 modulus, 1 self-timed PWM, 2 shifted PWM, 3 parked |
| polarity | input | 1 | Active output level |
| flag_on_lead | input | 1 | Self-timed PWM: also flag on A match |
| flag_clr | input | 1 | Write-1-to-clear strobe for the flag |
| pwm_out | output | 1 | Waveform output |
| flag | output | 1 | Sticky event flag |
| count | output | CNT_W | Current counter value |

## Verification
The hardest case to reach is the modulus start with the counter already above live A. No port presets the counter. The stimulus therefore lets the free-running shifted mode carry the counter to a high value, loads a small live A, and then switches to modulus, so the counter has to travel through the wrap. The staging-to-live copy points are observed only through the waveform and the flag. The bench therefore stages new values in mid-period and checks edge positions in the following period against a behavioural model on every clock.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

   typedef enum logic [1:0] {
      MODE_MODULUS   = 2'd0,
      MODE_SELF_PWM  = 2'd1,
      MODE_SHIFT_PWM = 2'd2,
      MODE_IDLE      = 2'd3
   } pwmc_mode_e;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_INC  = 2'd1,
      CNT_ONE  = 2'd2,
      CNT_ZERO = 2'd3
   } pwmc_cnt_op_e;

endpackage

// File: rtl/pwmc_counter.sv
module pwmc_counter
   import pwmc_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  pwmc_cnt_op_e op,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] ONE_V = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case (op)
            CNT_INC:  cnt <= cnt + ONE_V;
            CNT_ONE:  cnt <= ONE_V;
            CNT_ZERO: cnt <= '0;
            default:  cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/pwmc_dbuf.sv
module pwmc_dbuf #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stage_we,
   input  logic         live_we,
   input  logic [W-1:0] wdata,
   input  logic         xfer,
   output logic [W-1:0] stage_q,
   output logic [W-1:0] live_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (stage_we) begin
         stage_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (live_we) begin
         live_q <= wdata;
      end else if (xfer) begin
         live_q <= stage_q;
      end
   end

   // R2
   live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_we |=> live_q == $past(wdata));

   // R2
   stage_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_we |=> stage_q == $past(wdata));

endmodule

// File: rtl/pwmc_flag.sv
module pwmc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= set | (flag_q & ~clr);
      end
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag_q);

   // R11
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag_q);

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
   import pwmc_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       mode_sel,
   input  logic             polarity,
   input  logic             flag_on_lead,
   input  logic             flag_clr,
   output logic             pwm_out,
   output logic             flag,
   output logic [CNT_W-1:0] count
);

   localparam int NSLOT = 2;
   localparam int SLOT_A = 0;
   localparam int SLOT_B = 1;
   localparam logic [CNT_W-1:0] CNT_ONE_V = CNT_W'(1);

   initial begin
      assert (CNT_W >= 4 && CNT_W <= 32)
         else $error("pwm_cmp_channel: CNT_W must lie in 4..32");
   end

   pwmc_mode_e   mode_q;
   pwmc_mode_e   mode_now;
   logic         changing;
   logic         pwm_q;
   logic         out_d;
   logic         pend_q;
   logic         pend_d;
   logic         set_evt;
   pwmc_cnt_op_e cnt_op;
   logic [NSLOT-1:0] xfer;
   logic [CNT_W-1:0] stage [NSLOT];
   logic [CNT_W-1:0] live  [NSLOT];
   logic         hit_a;
   logic         hit_b;
   logic         hit_trig;

   assign mode_now = pwmc_mode_e'(mode_sel);
   assign changing = (mode_now != mode_q);

   // compare slots: A and B share one double-buffer structure
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [1:0] STAGE_CODE = 2'(s);
      localparam logic [1:0] LIVE_CODE  = 2'(s + NSLOT);
      pwmc_dbuf #(.W(CNT_W)) u_buf (
         .clk      (clk),
         .rst_n    (rst_n),
         .stage_we (wr_en && (wr_sel == STAGE_CODE)),
         .live_we  (wr_en && (wr_sel == LIVE_CODE)),
         .wdata    (wr_data),
         .xfer     (xfer[s]),
         .stage_q  (stage[s]),
         .live_q   (live[s])
      );
   end

   pwmc_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (cnt_op),
      .cnt   (count)
   );

   pwmc_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (set_evt),
      .clr    (flag_clr),
      .flag_q (flag)
   );

   assign hit_a    = (count == live[SLOT_A]);
   assign hit_b    = (count == live[SLOT_B]);
   assign hit_trig = (count == stage[SLOT_A]);

   always_comb begin
      cnt_op  = CNT_HOLD;
      xfer    = '0;
      set_evt = 1'b0;
      out_d   = pwm_q;
      pend_d  = pend_q;
      if (changing) begin
         out_d  = ~polarity;
         pend_d = 1'b0;
      end else begin
         unique case (mode_q)
            MODE_MODULUS: begin
               out_d        = ~polarity;
               xfer[SLOT_A] = (count == CNT_ONE_V);
               if (hit_a) begin
                  cnt_op  = CNT_ONE;
                  set_evt = 1'b1;
               end else begin
                  cnt_op = CNT_INC;
               end
            end
            MODE_SELF_PWM: begin
               xfer[SLOT_A] = pend_q;
               xfer[SLOT_B] = pend_q;
               pend_d       = 1'b0;
               if (hit_b) begin
                  cnt_op  = CNT_ZERO;
                  out_d   = ~polarity;
                  pend_d  = 1'b1;
                  set_evt = 1'b1;
               end else begin
                  cnt_op = CNT_INC;
                  if (hit_a) begin
                     out_d   = polarity;
                     set_evt = flag_on_lead;
                  end
               end
            end
            MODE_SHIFT_PWM: begin
               cnt_op       = CNT_INC;
               xfer[SLOT_B] = hit_a;
               set_evt      = hit_trig;
               if (hit_b) begin
                  out_d = ~polarity;
               end else if (hit_a) begin
                  out_d = polarity;
               end
            end
            default: begin
               out_d = ~polarity;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IDLE;
         pwm_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         mode_q <= mode_now;
         pwm_q  <= out_d;
         pend_q <= pend_d;
      end
   end

   assign pwm_out = pwm_q;

   // R3
   mod_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!changing && mode_q == MODE_MODULUS && hit_a) |=> (count == CNT_ONE_V && flag));

   // R6
   pwm_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!changing && mode_q == MODE_SELF_PWM && hit_b)
         |=> (count == '0 && pwm_out == !$past(polarity)));

   // R7
   pwm_b_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!changing && mode_q == MODE_SELF_PWM && pend_q && !(wr_en && wr_sel == 2'd3))
         |=> live[SLOT_B] == $past(stage[SLOT_B]));

   // R10
   trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!changing && mode_q == MODE_SHIFT_PWM && hit_trig) |=> flag);

   // R12
   mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      changing |=> (pwm_out == !$past(polarity) && $stable(count)));

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!changing && mode_q == MODE_IDLE) |=> ($stable(count) && !$rose(flag)));

endmodule

// File: tb/pwm_cmp_channel_bench.sv
module pwm_cmp_channel_bench;

   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   mode_sel = 2'd3;
   logic         polarity = 1'b0;
   logic         flag_on_lead = 1'b0;
   logic         flag_clr = 1'b0;
   logic         pwm_out;
   logic         flag;
   logic [W-1:0] count;

   int errors = 0;
   int checks = 0;
   bit model_on = 1'b0;

   // behavioural reference state
   int m_cnt, m_a1, m_a2, m_b1, m_b2, m_mode;
   bit m_out, m_flag, m_pend;

   always #10 clk = ~clk;

   pwm_cmp_channel #(.CNT_W(W)) u_pwm_cmp_channel (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .mode_sel     (mode_sel),
      .polarity     (polarity),
      .flag_on_lead (flag_on_lead),
      .flag_clr     (flag_clr),
      .pwm_out      (pwm_out),
      .flag         (flag),
      .count        (count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin : ref_model
      int nc, na1, na2, nb1, nb2;
      bit no, np, st;
      if (!rst_n) begin
         m_cnt = 0; m_a1 = 0; m_a2 = 0; m_b1 = 0; m_b2 = 0;
         m_mode = 3; m_out = 0; m_flag = 0; m_pend = 0;
      end else begin
         nc = m_cnt; na1 = m_a1; na2 = m_a2; nb1 = m_b1; nb2 = m_b2;
         no = m_out; np = m_pend; st = 0;
         if (int'(mode_sel) != m_mode) begin
            no = !polarity; np = 0;
         end else if (m_mode == 0) begin
            no = !polarity;
            if (m_cnt == 1) na1 = m_a2;
            if (m_cnt == m_a1) begin nc = 1; st = 1; end
            else nc = (m_cnt + 1) & MAXV;
         end else if (m_mode == 1) begin
            if (m_pend) begin na1 = m_a2; nb1 = m_b2; end
            np = 0;
            if (m_cnt == m_b1) begin nc = 0; no = !polarity; np = 1; st = 1; end
            else begin
               nc = (m_cnt + 1) & MAXV;
               if (m_cnt == m_a1) begin no = polarity; st = flag_on_lead; end
            end
         end else if (m_mode == 2) begin
            nc = (m_cnt + 1) & MAXV;
            if (m_cnt == m_a1) nb1 = m_b2;
            if (m_cnt == m_a2) st = 1;
            if (m_cnt == m_b1) no = !polarity;
            else if (m_cnt == m_a1) no = polarity;
         end else begin
            no = !polarity;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: na2 = int'(wr_data);
               2'd1: nb2 = int'(wr_data);
               2'd2: na1 = int'(wr_data);
               default: nb1 = int'(wr_data);
            endcase
         end
         m_flag = st || (m_flag && !flag_clr);
         m_cnt = nc; m_a1 = na1; m_a2 = na2; m_b1 = nb1; m_b2 = nb2;
         m_out = no; m_pend = np; m_mode = int'(mode_sel);
      end
   end

   // every-clock comparison against the model, tagged by the model's mode
   always @(negedge clk) begin
      if (model_on) begin
         string tg;
         case (m_mode)
            0: tg = "R3 model";
            1: tg = "R6 model";
            2: tg = "R9 model";
            default: tg = "R13 model";
         endcase
         chk({tg, " count"}, int'(count), m_cnt);
         chk({tg, " pwm_out"}, int'(pwm_out), int'(m_out));
         chk({tg, " flag"}, int'(flag), int'(m_flag));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int sel, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clr_pulse();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic wait_cnt(input int v, input string tag);
      for (int i = 0; i < 700; i++) begin
         @(negedge clk);
         if (int'(count) == v) return;
      end
      chk({tag, " count never reached"}, int'(count), v);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int held;
      cyc(3);
      // R1 reset state
      chk("R1 count in reset", int'(count), 0);
      chk("R1 flag in reset", int'(flag), 0);
      chk("R1 pwm_out in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      cyc(2);
      // R13 parked after reset
      chk("R13 parked count", int'(count), 0);
      chk("R13 parked output", int'(pwm_out), 1);

      // R2 direct live loads and staged values
      wr(2, 3);
      wr(3, 9);
      wr(0, 5);
      wr(1, 12);
      chk("R13 count held during writes", int'(count), 0);

      // self-timed PWM, active high
      @(negedge clk);
      polarity = 1'b1;
      mode_sel = 2'd1;
      wait_cnt(3, "R6");
      chk("R6 inactive up to A", int'(pwm_out), 0);
      @(negedge clk);
      chk("R2 live A=3 sets leading edge", int'(pwm_out), 1);
      wait_cnt(9, "R6");
      chk("R6 active until B", int'(pwm_out), 1);
      @(negedge clk);
      chk("R6 B match clears counter", int'(count), 0);
      chk("R6 B match gives inactive level", int'(pwm_out), 0);
      chk("R8 B match sets flag", int'(flag), 1);

      // R7 staged 5/12 became live at the start of this period
      wait_cnt(5, "R7");
      chk("R7 new A not yet matched", int'(pwm_out), 0);
      @(negedge clk);
      chk("R7 new A=5 leading edge", int'(pwm_out), 1);
      wait_cnt(12, "R7");
      @(negedge clk);
      chk("R7 new B=12 period end", int'(count), 0);

      // R8 flag_on_lead selection
      clr_pulse();
      wait_cnt(7, "R8");
      chk("R8 no flag on A when disabled", int'(flag), 0);
      flag_on_lead = 1'b1;
      wait_cnt(1, "R8");
      clr_pulse();
      wait_cnt(4, "R8");
      chk("R8 flag cleared before A", int'(flag), 0);
      wait_cnt(6, "R8");
      chk("R8 flag on A when enabled", int'(flag), 1);

      // R11 set beats a concurrent clear
      @(negedge clk);
      flag_clr = 1'b1;
      wait_cnt(12, "R11");
      chk("R11 held clear empties flag", int'(flag), 0);
      @(negedge clk);
      chk("R11 set wins over clear", int'(flag), 1);
      @(negedge clk);
      chk("R11 clear after set", int'(flag), 0);
      flag_clr = 1'b0;

      // R12 switch to shifted PWM
      @(negedge clk);
      held = int'(count);
      mode_sel = 2'd2;
      @(negedge clk);
      chk("R12 output inactive on switch", int'(pwm_out), 0);
      chk("R12 counter held on switch", int'(count), held);
      wait_cnt(6, "R12");
      chk("R12 live A kept across switch", int'(pwm_out), 1);
      chk("R12 staged A kept as trigger", int'(flag), 1);

      // R9 / R10 shifted PWM with trigger
      wr(2, 20);
      wr(3, 40);
      wr(0, 30);
      wr(1, 60);
      wait_cnt(0, "R9");
      clr_pulse();
      wait_cnt(21, "R9");
      chk("R9 leading edge at A", int'(pwm_out), 1);
      wait_cnt(30, "R10");
      chk("R10 no flag before trigger", int'(flag), 0);
      @(negedge clk);
      chk("R10 flag at staged A", int'(flag), 1);
      wait_cnt(41, "R9");
      chk("R9 staged B copied on A match", int'(pwm_out), 1);
      wait_cnt(61, "R9");
      chk("R9 trailing edge at new B", int'(pwm_out), 0);
      wait_cnt(MAXV, "R9");
      @(negedge clk);
      chk("R9 free run wraps", int'(count), 0);

      // R5 modulus entry above A
      wait_cnt(200, "R5");
      wr(2, 10);
      wr(0, 10);
      @(negedge clk);
      mode_sel = 2'd0;
      clr_pulse();
      wait_cnt(MAXV, "R5");
      chk("R5 count passes A up to all ones", int'(count), MAXV);
      @(negedge clk);
      chk("R5 wrap to zero", int'(count), 0);
      chk("R3 output inactive", int'(pwm_out), 0);
      wait_cnt(10, "R3");
      @(negedge clk);
      chk("R3 match reloads one", int'(count), 1);
      chk("R3 match sets flag", int'(flag), 1);

      // R4 staged A copies only at count one
      wr(0, 7);
      wait_cnt(7, "R4");
      @(negedge clk);
      chk("R4 staged A not yet live", int'(count), 8);
      wait_cnt(1, "R4");
      wait_cnt(7, "R4");
      @(negedge clk);
      chk("R4 staged A live after count one", int'(count), 1);

      // R13 parked mode
      @(negedge clk);
      mode_sel = 2'd3;
      cyc(2);
      held = int'(count);
      cyc(5);
      chk("R13 count held when parked", int'(count), held);
      chk("R13 output inactive when parked", int'(pwm_out), 0);
      polarity = 1'b0;
      cyc(2);
      chk("R13 output follows polarity", int'(pwm_out), 1);

      cyc(3);
      summary();
      $finish;
   end

endmodule